// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block keeps exceptions precise in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each instruction in flight carries a small fault vector with it. A stage that detects a fault only sets a bit in that vector, and the pipeline keeps moving. Nothing is acted on until the instruction reaches writeback. Because instructions reach writeback in program order, the oldest faulting instruction is always the one reported. This holds even when a younger instruction faulted in an earlier stage and at an earlier time.

A faulted instruction may not store to memory or write the register file. While it sits in writeback, the store of the instruction behind it is also held back. When a faulted instruction reaches writeback, the block flushes every younger slot in the same clock edge. At that edge it also latches the instruction's PC and a cause code. In the next cycle it raises a one-cycle trap pulse together with the handler fetch address. The fault sources, the memories and the handler are outside the block. The block only sees per-stage fault strobes and per-instruction write requests.

Top module: `exc_precise_track`

## Requirements
- R1: While reset is held and in the first cycle after it, no slot is occupied and st_en, rf_en, flush and trap_valid are 0. trap_epc and trap_cause are 0.
- R2: The fault vector has 8 bits: bit 0 instruction page fault, bit 1 instruction misalignment, bit 2 instruction protection, bit 3 undefined opcode, bit 4 arithmetic, bit 5 data page fault, bit 6 data misalignment, bit 7 data protection. fe_fault[2:0] maps to bits 0..2, dec_fault to bit 3, alu_fault to bit 4 and mem_fault[2:0] to bits 5..7. A reported trap_cause is 1 plus the index of the reported bit and is never 0.
- R3: st_en is 1 only when st_req is 1, the memory slot holds an instruction, that instruction's vector including this cycle's mem_fault is all zero, and the writeback slot holds no faulted instruction.
- R4: rf_en is 1 exactly when rf_req is 1 and the writeback slot holds an instruction whose vector is all zero.
- R5: flush is 1 exactly in a cycle where the writeback slot holds an instruction with a nonzero vector. A fault never causes flush while the instruction is in an earlier stage.
- R6: In the cycle after flush, trap_valid is 1 for one cycle, trap_epc holds the PC of the faulted instruction, and redir_pc equals the HANDLER_PC parameter.
- R7: The clock edge at the end of a flush cycle empties the decode, execute, memory and writeback slots. The instruction presented at fetch in that cycle is dropped. None of these instructions later produces st_en, rf_en or flush.
- R8: If an older instruction faults in the memory stage while a younger one faulted earlier at fetch, the trap reports the older instruction's PC and the data-side cause.
- R9: When one vector holds several bits, trap_cause reports the lowest-numbered bit, which is the one from the earliest stage.
- R10: A fault strobe for a stage that holds no instruction leaves no trace. It produces no flush and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_valid | input | 1 | An instruction is presented at fetch this cycle |
| fe_pc | input | PC_W | PC of the fetched instruction |
| fe_fault | input | 3 | Fetch-side faults: page, misalign, protection |
| dec_fault | input | 1 | Undefined opcode for the decode-slot instruction |
| alu_fault | input | 1 | Arithmetic fault for the execute-slot instruction |
| mem_fault | input | 3 | Data-side faults: page, misalign, protection |
| st_req | input | 1 | Memory-slot instruction wants to store |
| rf_req | input | 1 | Writeback-slot instruction wants to write a register |
| st_en | output | 1 | Store permitted this cycle |
| rf_en | output | 1 | Register write permitted this cycle |
| flush | output | 1 | Faulted instruction in writeback; younger slots cleared at this edge |
| trap_valid | output | 1 | One-cycle trap request |
| trap_epc | output | PC_W | Saved PC of the faulted instruction |
| trap_cause | output | 4 | Cause code of the trap |
| redir_pc | output | PC_W | Handler fetch address |

## Verification
Some rules hold on every cycle and are covered by the embedded properties. A flush is always followed by a trap pulse that carries the writeback PC. Two traps never come back to back. The trap cause is never zero. Neither write permission coincides with a flush. Every slot is empty after a flush. Other behaviour needs whole scenarios and is shown only by the bench. This covers ordering between an older memory fault and a younger fetch fault, and priority among several bits in one vector. It also covers the silent loss of strobes aimed at empty stages, and the dropping of every younger instruction that would otherwise have written.

// File: rtl/exc_pkg.sv
`timescale 1ns/100ps
package exc_pkg;
  localparam int NFAULT  = 8;
  localparam int CAUSE_W = 4;
  localparam int NSLOT   = 4;

  // bit positions inside the per-instruction fault vector, earliest stage lowest
  localparam int B_IPAGE = 0;
  localparam int B_UNDEF = 3;
  localparam int B_ARITH = 4;
  localparam int B_DPAGE = 5;

  // cause = 1 + index of the lowest set bit; 0 when the vector is clean
  function automatic logic [CAUSE_W-1:0] first_cause(input logic [NFAULT-1:0] s);
    logic [CAUSE_W-1:0] c;
    c = '0;
    for (int i = NFAULT - 1; i >= 0; i--) begin
      if (s[i]) c = CAUSE_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/exc_stage_slot.sv
`timescale 1ns/100ps
module exc_stage_slot
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [NFAULT-1:0] in_status,
  input  logic [NFAULT-1:0] inject,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_pc,
  output logic [NFAULT-1:0] out_status
);
  logic [NFAULT-1:0] merged;
  assign merged = in_valid ? (in_status | inject) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_pc     <= '0;
      out_status <= '0;
    end else if (flush) begin
      out_valid  <= 1'b0;
      out_pc     <= '0;
      out_status <= '0;
    end else begin
      out_valid  <= in_valid;
      out_pc     <= in_pc;
      out_status <= merged;
    end
  end

  // R7
  slot_flushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/exc_cause_enc.sv
`timescale 1ns/100ps
module exc_cause_enc
  import exc_pkg::*;
(
  input  logic [NFAULT-1:0]  status,
  output logic               any,
  output logic [CAUSE_W-1:0] code
);
  assign any  = |status;
  assign code = first_cause(status);
endmodule

// File: rtl/exc_precise_track.sv
`timescale 1ns/100ps
module exc_precise_track
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fe_valid,
  input  logic [PC_W-1:0]    fe_pc,
  input  logic [2:0]         fe_fault,
  input  logic               dec_fault,
  input  logic               alu_fault,
  input  logic [2:0]         mem_fault,
  input  logic               st_req,
  input  logic               rf_req,
  output logic               st_en,
  output logic               rf_en,
  output logic               flush,
  output logic               trap_valid,
  output logic [PC_W-1:0]    trap_epc,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [PC_W-1:0]    redir_pc
);
  // index 0 is the fetch input, 1..NSLOT are decode, execute, memory, writeback
  logic              sv  [0:NSLOT];
  logic [PC_W-1:0]   spc [0:NSLOT];
  logic [NFAULT-1:0] sst [0:NSLOT];
  logic [NFAULT-1:0] inj [0:NSLOT-1];

  assign sv[0]  = fe_valid;
  assign spc[0] = fe_pc;
  assign sst[0] = '0;

  // strobe for the stage the instruction occupies before the next edge
  assign inj[0] = NFAULT'(fe_fault)  << B_IPAGE;
  assign inj[1] = NFAULT'(dec_fault) << B_UNDEF;
  assign inj[2] = NFAULT'(alu_fault) << B_ARITH;
  assign inj[3] = NFAULT'(mem_fault) << B_DPAGE;

  // named events for the checks
  logic              wb_bad;
  logic              mem_clean;
  logic [PC_W-1:0]   wb_pc;
  logic [CAUSE_W-1:0] wb_code;

  generate
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      exc_stage_slot #(.PC_W(PC_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (wb_bad),
        .in_valid   (sv[k]),
        .in_pc      (spc[k]),
        .in_status  (sst[k]),
        .inject     (inj[k]),
        .out_valid  (sv[k+1]),
        .out_pc     (spc[k+1]),
        .out_status (sst[k+1])
      );
    end
  endgenerate

  logic wb_any;
  exc_cause_enc u_enc (
    .status (sst[NSLOT]),
    .any    (wb_any),
    .code   (wb_code)
  );

  assign wb_bad    = sv[NSLOT] & wb_any;
  assign wb_pc     = spc[NSLOT];
  assign mem_clean = sv[NSLOT-1] & ~|(sst[NSLOT-1] | inj[NSLOT-1]);

  assign flush    = wb_bad;
  assign st_en    = st_req & mem_clean & ~wb_bad;
  assign rf_en    = rf_req & sv[NSLOT] & ~wb_any;
  assign redir_pc = HANDLER_PC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_epc   <= '0;
      trap_cause <= '0;
    end else begin
      trap_valid <= wb_bad;
      if (wb_bad) begin
        trap_epc   <= wb_pc;
        trap_cause <= wb_code;
      end
    end
  end

  // R6
  trap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> trap_valid && trap_epc == $past(wb_pc));
  // R5
  trap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !flush);
  // R2
  cause_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_cause != 0 && trap_cause <= CAUSE_W'(NFAULT)));
  // R4
  rf_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> !flush);
  // R3
  st_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !flush);
endmodule

// File: tb/exc_precise_track_bench.sv
`timescale 1ns/100ps
module exc_precise_track_bench;
  localparam int PW = 32;
  localparam logic [PW-1:0] HPC = 32'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fe_valid = 0, dec_fault = 0, alu_fault = 0, st_req = 0, rf_req = 0;
  logic [PW-1:0] fe_pc = '0;
  logic [2:0] fe_fault = '0, mem_fault = '0;
  logic st_en, rf_en, flush, trap_valid;
  logic [PW-1:0] trap_epc, redir_pc;
  logic [3:0] trap_cause;

  always #2.5 clk = ~clk;

  exc_precise_track #(.PC_W(PW), .HANDLER_PC(HPC)) u_exc_precise_track (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_pc(fe_pc),
    .fe_fault(fe_fault), .dec_fault(dec_fault), .alu_fault(alu_fault),
    .mem_fault(mem_fault), .st_req(st_req), .rf_req(rf_req),
    .st_en(st_en), .rf_en(rf_en), .flush(flush), .trap_valid(trap_valid),
    .trap_epc(trap_epc), .trap_cause(trap_cause), .redir_pc(redir_pc));

  int checks = 0, bad = 0;
  int flush_seen = 0, rf_seen = 0, st_seen = 0;
  bit done = 0;

  // bench model: slots 1..4 = decode, execute, memory, writeback
  bit       mv  [1:4];
  bit [31:0] mpc [1:4];
  bit [7:0] mst [1:4];
  bit       e_tv;
  bit [31:0] e_epc;
  bit [3:0] e_cause;

  function automatic bit [3:0] want_cause(bit [7:0] s);
    for (int i = 0; i < 8; i++) if (s[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(bit v, bit [31:0] pc, bit [2:0] ff, bit df, bit af,
                      bit [2:0] mf, bit sr, bit rr);
    bit [7:0] strobe [0:3];
    bit ex_flush, ex_st, ex_rf;
    bit       nv  [1:4];
    bit [31:0] npc [1:4];
    bit [7:0] nst [1:4];
    @(negedge clk);
    fe_valid = v; fe_pc = pc; fe_fault = ff; dec_fault = df;
    alu_fault = af; mem_fault = mf; st_req = sr; rf_req = rr;
    #1;
    strobe[0] = {5'b0, ff};
    strobe[1] = {4'b0, df, 3'b0};
    strobe[2] = {3'b0, af, 4'b0};
    strobe[3] = {mf, 5'b0};
    ex_flush = mv[4] && (mst[4] != 0);
    ex_st = sr && mv[3] && ((mst[3] | strobe[3]) == 0) && !ex_flush;
    ex_rf = rr && mv[4] && (mst[4] == 0);
    chk("R5 flush", 32'(flush), 32'(ex_flush));
    chk("R3 st_en", 32'(st_en), 32'(ex_st));
    chk("R4 rf_en", 32'(rf_en), 32'(ex_rf));
    chk("R6 trap_valid", 32'(trap_valid), 32'(e_tv));
    if (e_tv) begin
      chk("R6 trap_epc", trap_epc, e_epc);
      chk("R2 trap_cause", 32'(trap_cause), 32'(e_cause));
      chk("R6 redir_pc", redir_pc, HPC);
    end
    if (flush) flush_seen++;
    if (rf_en) rf_seen++;
    if (st_en) st_seen++;
    // next model state
    for (int k = 1; k <= 4; k++) begin
      if (ex_flush) begin
        nv[k] = 0; npc[k] = 0; nst[k] = 0;
      end else if (k == 1) begin
        nv[1] = v; npc[1] = pc; nst[1] = v ? strobe[0] : 8'h0;
      end else begin
        nv[k] = mv[k-1]; npc[k] = mpc[k-1];
        nst[k] = mv[k-1] ? (mst[k-1] | strobe[k-1]) : 8'h0;
      end
    end
    @(posedge clk);
    e_tv = ex_flush;
    if (ex_flush) begin
      e_epc = mpc[4];
      e_cause = want_cause(mst[4]);
    end
    for (int k = 1; k <= 4; k++) begin
      mv[k] = nv[k]; mpc[k] = npc[k]; mst[k] = nst[k];
    end
  endtask

  task automatic idle(int n, bit sr, bit rr);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, sr, rr);
  endtask

  initial begin
    int r;
    for (int k = 1; k <= 4; k++) begin mv[k] = 0; mpc[k] = 0; mst[k] = 0; end
    e_tv = 0; e_epc = 0; e_cause = 0;
    r = $urandom(32'd7);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flush in reset", 32'(flush), 0);
    chk("R1 trap_valid in reset", 32'(trap_valid), 0);
    chk("R1 trap_epc in reset", trap_epc, 0);
    chk("R1 trap_cause in reset", 32'(trap_cause), 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 1, 1);
    #1;
    chk("R1 trap_valid after reset", 32'(trap_valid), 0);

    // R8: older memory fault beats younger fetch fault
    step(1, 32'h100, 3'b000, 0, 0, 3'b000, 0, 0);
    step(1, 32'h104, 3'b001, 0, 0, 3'b000, 0, 0);
    step(0, 0, 0, 0, 0, 3'b000, 0, 0);
    step(0, 0, 0, 0, 0, 3'b001, 0, 0);
    step(1, 32'h108, 0, 0, 0, 0, 1, 1);
    #1;
    chk("R8 trap_valid", 32'(trap_valid), 1);
    chk("R8 older pc reported", trap_epc, 32'h100);
    chk("R8 data page cause", 32'(trap_cause), 6);
    // R7: younger instructions were dropped
    flush_seen = 0; rf_seen = 0; st_seen = 0;
    idle(5, 1, 1);
    chk("R7 no flush from dropped", 32'(flush_seen), 0);
    chk("R7 no rf_en from dropped", 32'(rf_seen), 0);
    chk("R7 no st_en from dropped", 32'(st_seen), 0);

    // R9: fetch protection plus arithmetic on one instruction -> cause 3
    step(1, 32'h200, 3'b100, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R9 epc", trap_epc, 32'h200);
    chk("R9 earliest bit wins", 32'(trap_cause), 3);
    idle(4, 0, 0);

    // R10: strobes aimed at an empty pipeline
    flush_seen = 0;
    for (int i = 0; i < 6; i++) step(0, 0, 3'b111, 1, 1, 3'b111, 0, 0);
    idle(5, 0, 0);
    chk("R10 no flush from empty stages", 32'(flush_seen), 0);
    chk("R10 no trap", 32'(trap_valid), 0);

    // random traffic, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      bit v;
      bit [2:0] ff, mf;
      v  = ($urandom % 10) < 7;
      ff = (($urandom % 32) == 0) ? 3'($urandom) : 3'b0;
      mf = (($urandom % 24) == 0) ? 3'($urandom) : 3'b0;
      step(v, $urandom & 32'hFFFF_FFFC, ff, ($urandom % 40) == 0,
           ($urandom % 40) == 0, mf, 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule